// File: doc/BRIEF.md
# PCM/DSD Input Format Auto-Detector

This block sits at the serial input of a DAC front end. One line carries either the left/right frame clock of a PCM stream or the one-bit data of a DSD stream, and the block works out which of the two is present. It runs only on the bit clock, so it needs no master clock. While enabled, it looks at the shared line for a fixed window of bit clocks and classifies what it sees. The new format takes effect on the next rising edge of the line. When the format actually changes, a stretched internal reset goes out to the downstream decoders. A later check is made only after both channels have been silent for a selectable time. In DSD mode a stuck data line can raise a mute request.

All signals here are plain control and status levels. The block has no streaming interface, so no valid/ready handshake or back-pressure applies. The timing parameters are FS_CLKS (bit clocks per sample period, 64 by default), WIN_LEN (34), HOLD_CLKS (32), FULL_RUN (28) and ZERO_BASE_FS (1024). The internal reset lasts RST_LEN = 3*FS_CLKS + FS_CLKS/2 bit clocks, which is 3.5 sample periods.

Top module: `pcm_dsd_sense`

## Requirements
- R1: A detection pass runs only while auto_en is 1, soft_rst is 0 and pdn_n is 1. When auto_en is 0 or soft_rst is 1, any pass in progress is dropped and mode_dsd holds its value. Raising the enable again starts a fresh first pass one clock later.
- R2: A pass samples line_in on WIN_LEN rising bit-clock edges. A transition is a sample that differs from the one before it, and the first sample of a window is never counted as a transition. If two transitions in the window lie fewer than HOLD_CLKS samples apart, the result is DSD. If at least one transition occurs and none lie that close, the result is PCM. If no transition occurs, there is no result and the mode is left alone.
- R3: A result is applied at the first later edge where line_in is sampled 1 and the previous sample was 0. mode_dsd (1 = DSD, 0 = PCM) changes at no other time.
- R4: pdn_n low clears mode_dsd, int_rst and mute_req asynchronously. If the line then stays static with the clock running, the mode stays PCM.
- R5: When an applied result differs from mode_dsd, int_rst is high for exactly RST_LEN cycles, starting with the cycle in which the new mode shows. It does not rise when the result matches the current mode.
- R6: After a pass ends and no hunt is active, a new pass starts only after zero_l and zero_r have both been 1 on LIMIT consecutive edges. LIMIT = ZERO_BASE_FS * FS_CLKS * 2^tmo_sel, so tmo_sel 0..3 selects 1x, 2x, 4x or 8x. Any edge where a zero flag is 0 restarts the count.
- R7: A pass started by the silence timeout begins a hunt, in which passes repeat back to back. The hunt ends, and counting restarts, at the end of the first pass during which either zero flag was seen at 0.
- R8: mute_req is 1 when mute_en is 1, mode_dsd is 1 and line_in has gone without a transition for at least FULL_RUN consecutive edges. It falls after the first transition.
- R9: In DSD mode, a stopped bit clock or a line with no transitions leaves mode_dsd at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bclk | input | 1 | Bit clock, rising edge active |
| pdn_n | input | 1 | Power-down, active low asynchronous reset |
| auto_en | input | 1 | Automatic format detection enable |
| soft_rst | input | 1 | Soft reset control; detection runs only when 0 |
| tmo_sel | input | 2 | Silence timeout select (1x, 2x, 4x, 8x of the base) |
| line_in | input | 1 | Shared frame-clock / DSD data line |
| zero_l | input | 1 | Left channel data is zero |
| zero_r | input | 1 | Right channel data is zero |
| mute_en | input | 1 | Enable for mute on DSD full scale |
| mode_dsd | output | 1 | 1 = DSD, 0 = PCM |
| int_rst | output | 1 | Stretched internal reset after a mode change |
| mute_req | output | 1 | Mute request on DSD full-scale input |

## Verification
Two events can fall on the same edge: the end of a hunting pass, which is either a rising edge that applies a result or a window with no transition, and the first nonzero flag of the hunt. In that case the flag must still stop the hunt. The bench provokes this by toggling the zero flags at random while it drives PCM, DSD and static segments of random length. Its behavioural model settles every edge in requirement order and is compared with the mode, the reset and the mute outputs on every clock. A second overlap, where a mode change and a full-scale run occur together, is covered by the same comparison.

// File: rtl/pds_pkg.sv
package pds_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WIN,
    ST_PEND,
    ST_ARMED
  } det_st_e;
endpackage

// File: rtl/pds_window.sv
// Classifies one window of line samples by the spacing of transitions.
module pds_window #(
  parameter int WIN_LEN = 34,
  parameter int HOLD    = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic trans,
  output logic done,
  output logic found,
  output logic is_dsd
);
  localparam int CW = $clog2(WIN_LEN);

  logic [CW-1:0] cnt, last;
  logic          seen, short_q, tr_use, gap_short;

  assign tr_use    = active && trans && (cnt != '0);
  assign gap_short = (32'(cnt) - 32'(last)) < 32'(HOLD);
  assign found     = seen | tr_use;
  assign is_dsd    = short_q | (tr_use && seen && gap_short);
  assign done      = active && (cnt == CW'(WIN_LEN - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      last    <= '0;
      seen    <= 1'b0;
      short_q <= 1'b0;
    end else if (!active || done) begin
      cnt     <= '0;
      last    <= '0;
      seen    <= 1'b0;
      short_q <= 1'b0;
    end else begin
      cnt     <= cnt + CW'(1);
      short_q <= is_dsd;
      if (tr_use) begin
        last <= cnt;
        seen <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/pds_zero_wait.sv
// Counts consecutive silent edges while armed; fires at the selected limit.
module pds_zero_wait #(
  parameter int BASE_CLKS = 65536
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       arm,
  input  logic       quiet,
  input  logic [1:0] tmo_sel,
  output logic       expire
);
  localparam int CW = $clog2(BASE_CLKS * 8) + 1;

  logic [CW-1:0] cnt, lim;

  assign lim    = CW'(BASE_CLKS) << tmo_sel;
  assign expire = arm && quiet && (cnt == lim - CW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      cnt <= '0;
    else if (!arm || !quiet || expire) cnt <= '0;
    else                             cnt <= cnt + CW'(1);
  end
endmodule

// File: rtl/pds_fullscale.sv
// Saturating run length of samples without a transition.
module pds_fullscale #(
  parameter int RUN_MIN = 28
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trans,
  output logic full
);
  localparam int CW = $clog2(RUN_MIN + 1);

  logic [CW-1:0] run;

  assign full = (run == CW'(RUN_MIN));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     run <= '0;
    else if (trans)                 run <= '0;
    else if (run != CW'(RUN_MIN))   run <= run + CW'(1);
  end
endmodule

// File: rtl/pcm_dsd_sense.sv
module pcm_dsd_sense
  import pds_pkg::*;
#(
  parameter int FS_CLKS      = 64,
  parameter int WIN_LEN      = 34,
  parameter int HOLD_CLKS    = 32,
  parameter int FULL_RUN     = 28,
  parameter int ZERO_BASE_FS = 1024
) (
  input  logic       bclk,
  input  logic       pdn_n,
  input  logic       auto_en,
  input  logic       soft_rst,
  input  logic [1:0] tmo_sel,
  input  logic       line_in,
  input  logic       zero_l,
  input  logic       zero_r,
  input  logic       mute_en,
  output logic       mode_dsd,
  output logic       int_rst,
  output logic       mute_req
);
  localparam int RST_LEN = 3 * FS_CLKS + FS_CLKS / 2;
  localparam int RCW     = $clog2(RST_LEN + 1);

  det_st_e        st;
  logic           line_q, hunt, stop_q, res_dsd;
  logic           trans, rise, quiet, en, stop_now;
  logic           win_done, win_found, win_dsd, expire, full;
  logic           apply, pass_end;
  logic [RCW-1:0] rcnt;

  assign trans    = line_in ^ line_q;
  assign rise     = line_in & ~line_q;
  assign quiet    = zero_l & zero_r;
  assign en       = auto_en & ~soft_rst;
  assign stop_now = stop_q | ~quiet;
  assign apply    = en && (st == ST_PEND) && rise;
  assign pass_end = en && (((st == ST_WIN) && win_done && !win_found) || apply);

  pds_window #(.WIN_LEN(WIN_LEN), .HOLD(HOLD_CLKS)) u_win (
    .clk    (bclk),
    .rst_n  (pdn_n),
    .active (en && (st == ST_WIN)),
    .trans  (trans),
    .done   (win_done),
    .found  (win_found),
    .is_dsd (win_dsd)
  );

  pds_zero_wait #(.BASE_CLKS(ZERO_BASE_FS * FS_CLKS)) u_zero (
    .clk     (bclk),
    .rst_n   (pdn_n),
    .arm     (st == ST_ARMED),
    .quiet   (quiet),
    .tmo_sel (tmo_sel),
    .expire  (expire)
  );

  pds_fullscale #(.RUN_MIN(FULL_RUN)) u_full (
    .clk   (bclk),
    .rst_n (pdn_n),
    .trans (trans),
    .full  (full)
  );

  // Pass sequencing: first pass, pending apply, silence wait, hunt loop.
  always_ff @(posedge bclk or negedge pdn_n) begin
    if (!pdn_n) begin
      st      <= ST_IDLE;
      line_q  <= 1'b0;
      hunt    <= 1'b0;
      stop_q  <= 1'b0;
      res_dsd <= 1'b0;
    end else begin
      line_q <= line_in;
      if (!en) begin
        st     <= ST_IDLE;
        hunt   <= 1'b0;
        stop_q <= 1'b0;
      end else begin
        if (hunt && !quiet) stop_q <= 1'b1;
        unique case (st)
          ST_IDLE:  st <= ST_WIN;
          ST_WIN: begin
            if (win_done && win_found) begin
              st      <= ST_PEND;
              res_dsd <= win_dsd;
            end
          end
          ST_PEND: begin
          end
          ST_ARMED: begin
            if (expire) begin
              st     <= ST_WIN;
              hunt   <= 1'b1;
              stop_q <= 1'b0;
            end
          end
        endcase
        if (pass_end) begin
          stop_q <= 1'b0;
          if (hunt && !stop_now) begin
            st <= ST_WIN;
          end else begin
            st   <= ST_ARMED;
            hunt <= 1'b0;
          end
        end
      end
    end
  end

  // Mode register and stretched reset after a real change.
  always_ff @(posedge bclk or negedge pdn_n) begin
    if (!pdn_n) begin
      mode_dsd <= 1'b0;
      rcnt     <= '0;
    end else if (apply && (res_dsd != mode_dsd)) begin
      mode_dsd <= res_dsd;
      rcnt     <= RCW'(RST_LEN);
    end else if (rcnt != '0) begin
      rcnt <= rcnt - RCW'(1);
    end
  end

  assign int_rst  = (rcnt != '0);
  assign mute_req = mute_en & mode_dsd & full;
endmodule

// File: rtl/pds_checker.sv
module pds_checker (
  input logic clk,
  input logic rst_n,
  input logic auto_en,
  input logic soft_rst,
  input logic line_in,
  input logic mode_dsd,
  input logic int_rst,
  input logic mute_req
);
  AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!auto_en || soft_rst) |=> $stable(mode_dsd)); // R1

  AST_CHANGE_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mode_dsd) |-> ($past(line_in) && !$past(line_in, 2))); // R3

  AST_RESET_ON_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mode_dsd) |-> int_rst); // R5

  AST_MUTE_NO_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    mute_req |-> ($past(line_in) == $past(line_in, 2))); // R8
endmodule

bind pcm_dsd_sense pds_checker u_chk (
  .clk      (bclk),
  .rst_n    (pdn_n),
  .auto_en  (auto_en),
  .soft_rst (soft_rst),
  .line_in  (line_in),
  .mode_dsd (mode_dsd),
  .int_rst  (int_rst),
  .mute_req (mute_req)
);

// File: tb/pcm_dsd_sense_test.sv
module pcm_dsd_sense_test;
  localparam int PER   = 10;
  localparam int FSC   = 64;
  localparam int ZB    = 2;
  localparam int RSTL  = 3 * FSC + FSC / 2;

  logic clk = 1'b0, clk_run = 1'b1;
  logic pdn_n = 1'b0, auto_en = 1'b1, soft_rst = 1'b0, line_in = 1'b0;
  logic zero_l = 1'b0, zero_r = 1'b0, mute_en = 1'b0;
  logic [1:0] tmo_sel = 2'd0;
  logic mode_dsd, int_rst, mute_req;

  int checks = 0, errors = 0, rst_hi = 0, ph = 0;
  logic [15:0] lfsr = 16'hACE1;

  pcm_dsd_sense #(.FS_CLKS(FSC), .ZERO_BASE_FS(ZB)) uut (
    .bclk(clk), .pdn_n(pdn_n), .auto_en(auto_en), .soft_rst(soft_rst),
    .tmo_sel(tmo_sel), .line_in(line_in), .zero_l(zero_l), .zero_r(zero_r),
    .mute_en(mute_en), .mode_dsd(mode_dsd), .int_rst(int_rst), .mute_req(mute_req)
  );

  initial forever begin
    #(PER / 2);
    if (clk_run || clk) clk = ~clk;
  end

  // Behavioural reference model, advanced on each rising edge.
  int m_phase = 0, m_zc = 0, m_run = 0, m_rc = 0;
  bit m_mode = 0, m_prev = 0, m_hunt = 0, m_stop = 0, m_res = 0;
  bit hist[$];

  always @(posedge clk or negedge pdn_n) begin
    if (!pdn_n) begin
      m_phase = 0; m_zc = 0; m_run = 0; m_rc = 0;
      m_mode = 0; m_prev = 0; m_hunt = 0; m_stop = 0; m_res = 0;
      hist.delete();
    end else begin
      bit en, quiet, endp, cur;
      cur   = line_in;
      en    = auto_en && !soft_rst;
      quiet = zero_l && zero_r;
      endp  = 0;
      if (cur != m_prev) m_run = 0; else if (m_run < 28) m_run++;
      if (m_rc > 0) m_rc--;
      if (!en) begin
        m_phase = 0; m_hunt = 0; m_stop = 0;
      end else begin
        if (m_hunt && !quiet) m_stop = 1;
        case (m_phase)
          0: begin m_phase = 1; hist.delete(); end
          1: begin
            hist.push_back(cur);
            if (hist.size() == 34) begin
              int lt; bit sh, fnd;
              lt = -1; sh = 0; fnd = 0;
              for (int i = 1; i < 34; i++)
                if (hist[i] != hist[i-1]) begin
                  if (lt >= 0 && i - lt < 32) sh = 1;
                  lt = i; fnd = 1;
                end
              hist.delete();
              if (fnd) begin m_phase = 2; m_res = sh; end
              else endp = 1;
            end
          end
          2: if (cur && !m_prev) begin
            if (m_res != m_mode) begin m_mode = m_res; m_rc = RSTL; end
            endp = 1;
          end
          default: begin
            if (quiet) begin
              m_zc++;
              if (m_zc == ZB * FSC * (1 << tmo_sel)) begin
                m_phase = 1; hist.delete(); m_hunt = 1; m_stop = 0; m_zc = 0;
              end
            end else m_zc = 0;
          end
        endcase
        if (endp) begin
          if (m_hunt && !m_stop) begin m_phase = 1; hist.delete(); end
          else begin m_phase = 3; m_zc = 0; m_hunt = 0; end
          m_stop = 0;
        end
      end
      m_prev = cur;
    end
  end

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  // Every-clock comparison against the model.
  always @(negedge clk) begin
    if (pdn_n) begin
      chk("R3 mode", mode_dsd, m_mode);
      chk("R5 int_rst", int_rst, m_rc > 0);
      chk("R8 mute", mute_req, mute_en && m_mode && m_run >= 28);
      if (int_rst) rst_hi++;
    end
  end

  task automatic tick(input logic v);
    @(negedge clk); #1; line_in = v;
  endtask
  task automatic run_hold(input int n, input logic v);
    for (int k = 0; k < n; k++) tick(v);
  endtask
  task automatic run_pcm(input int n);
    for (int k = 0; k < n; k++) begin tick(logic'((ph / 32) % 2)); ph++; end
  endtask
  task automatic run_dsd(input int n);
    for (int k = 0; k < n; k++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      tick(lfsr[0]);
    end
  endtask
  task automatic zeros(input logic z);
    zero_l = z; zero_r = z;
  endtask

  initial begin
    #(PER * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    chk("R4 reset mode", mode_dsd, 1'b0);
    chk("R4 reset int_rst", int_rst, 1'b0);
    chk("R4 reset mute", mute_req, 1'b0);
    #1 pdn_n = 1'b1;
    run_hold(100, 1'b0);
    chk("R4 static line stays PCM", mode_dsd, 1'b0);
    run_pcm(200);
    chk("R2 PCM frame keeps PCM", mode_dsd, 1'b0);
    zeros(1'b1);
    rst_hi = 0;
    run_pcm(400);
    chk("R7 hunt on PCM no change", mode_dsd, 1'b0);
    chk("R5 no reset without change", logic'(rst_hi == 0), 1'b1);
    rst_hi = 0;
    run_dsd(300);
    chk("R2 DSD stream detected", mode_dsd, 1'b1);
    run_dsd(300);
    chk("R5 reset length", logic'(rst_hi == RSTL), 1'b1);
    zeros(1'b0);
    run_dsd(100);
    mute_en = 1'b1;
    run_hold(40, 1'b1);
    chk("R8 full-scale mute", mute_req, 1'b1);
    run_hold(2, 1'b0);
    chk("R8 mute clears on edge", mute_req, 1'b0);
    mute_en = 1'b0;
    run_hold(40, 1'b1);
    chk("R8 mute disabled", mute_req, 1'b0);
    clk_run = 1'b0;
    #(PER * 50);
    clk_run = 1'b1;
    run_hold(3, 1'b1);
    chk("R9 clock stop keeps DSD", mode_dsd, 1'b1);
    zeros(1'b1);
    run_hold(800, 1'b0);
    chk("R9 data stop keeps DSD", mode_dsd, 1'b1);
    ph = 0;
    run_pcm(600);
    chk("R2 PCM returns", mode_dsd, 1'b0);
    auto_en = 1'b0;
    run_dsd(800);
    chk("R1 disabled holds mode", mode_dsd, 1'b0);
    auto_en = 1'b1; soft_rst = 1'b1;
    run_dsd(800);
    chk("R1 soft reset holds mode", mode_dsd, 1'b0);
    soft_rst = 1'b0; zeros(1'b0);
    run_dsd(200);
    chk("R1 re-enable first pass", mode_dsd, 1'b1);
    tmo_sel = 2'd3;
    zeros(1'b1);
    for (int k = 0; k < 4; k++) begin
      run_pcm(900);
      zeros(1'b0); run_pcm(1); zeros(1'b1);
    end
    chk("R6 broken silence no pass", mode_dsd, 1'b1);
    run_pcm(1200);
    chk("R6 full timeout starts pass", mode_dsd, 1'b0);
    zeros(1'b0);
    run_pcm(200);
    run_dsd(500);
    chk("R7 hunt ended by nonzero", mode_dsd, 1'b0);
    for (int s = 0; s < 80; s++) begin
      int len, kind;
      len  = 50 + $urandom_range(0, 350);
      kind = $urandom_range(0, 2);
      tmo_sel = 2'($urandom_range(0, 1));
      mute_en = 1'($urandom_range(0, 1));
      auto_en = ($urandom_range(0, 9) != 0);
      for (int k = 0; k < len; k++) begin
        if ($urandom_range(0, 99) < 3) zeros(~zero_l);
        if (kind == 0) run_pcm(1);
        else if (kind == 1) run_dsd(1);
        else run_hold(1, 1'b1);
      end
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule